// File: doc/BRIEF.md
# Write-Combining Store Buffer with Store Fence

This block collects streaming stores that should bypass the cache and hands them to memory as whole-line writes. Each of its entries holds one line address, a line of data and one enable bit per byte. A 16-byte store lands in one half of a 32-byte line. If an open entry already holds that line, the store merges into it. Otherwise the store takes the next free entry. When no entry is free, the oldest entry is written out first. The store itself never reads the line from memory. If the line may also sit in a cache, the block asks for that copy to be evicted.

A byte-masked store form writes only the bytes whose mask byte has its top bit set. A fence request closes the store input until every posted entry has reached memory. The block then reports completion with a single-cycle pulse. Entries leave in the order they were allocated, over a valid/ready memory write port.

Top module: `wc_store_buffer`

## Requirements
- R1: A buffered store is not written to memory until its entry drains. A drained entry appears as one write on the memory port. That write carries the line-aligned address (low 5 bits zero), the line data and a 32-bit byte enable that is set only for the bytes that stores wrote.
- R2: A store to a line that an open entry holds merges into that entry without allocating. The line is written once. Its enables are the union of all the merged stores, and a later store's bytes replace earlier ones.
- R3: Store byte k goes to line byte 16*st_addr[4]+k. With st_masked_i=0 all 16 bytes are written. With st_masked_i=1, byte k is written only when bit 8*k+7 of st_mask_i is 1; the other seven bits of each mask byte have no effect.
- R4: A store with st_addr_i[3:0] not zero is accepted but not buffered. align_fault_o is high for exactly the cycle after acceptance, no evict request is made, and no memory write ever carries its bytes.
- R5: In the cycle after a buffered store is accepted with st_cached_i=1, evict_valid_o is high and evict_addr_o holds the store's line address. A buffered store with st_cached_i=0 raises no evict request.
- R6: From the cycle fence_req_i is high until fence_done_o pulses, st_ready_o is low, including in the request cycle itself.
- R7: fence_done_o pulses in the cycle right after the last posted entry completes its memory write. It pulses in the cycle after the request if nothing is posted.
- R8: Entries reach the memory port in the order in which they were allocated.
- R9: A store to a new line while all 4 entries are open is held (st_ready_o low). The oldest entry is written out, and the store is then accepted into the freed slot.
- R10: An entry whose 32 byte enables are all set drains without a fence.
- R11: After reset, st_ready_o is high and mw_valid_o, fence_done_o, align_fault_o and evict_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store offered |
| st_ready_o | output | 1 | Store accepted this cycle when valid |
| st_addr_i | input | 32 | Store byte address, 16-byte aligned |
| st_data_i | input | 128 | Store data, byte k in bits 8k+7:8k |
| st_masked_i | input | 1 | 1 selects the byte-masked form |
| st_mask_i | input | 128 | Mask bytes, bit 8k+7 enables byte k |
| st_cached_i | input | 1 | Line may be resident in a cache |
| fence_req_i | input | 1 | Fence request pulse |
| fence_done_o | output | 1 | Fence completion pulse |
| align_fault_o | output | 1 | Misaligned store pulse |
| evict_valid_o | output | 1 | Evict request for a cached copy |
| evict_addr_o | output | 32 | Line address to evict |
| mw_valid_o | output | 1 | Line write valid |
| mw_ready_i | input | 1 | Line write accepted |
| mw_addr_o | output | 32 | Line write address |
| mw_data_o | output | 256 | Line write data |
| mw_be_o | output | 32 | Line write byte enables |

## Verification
The assertions check on every cycle the rules that can be seen locally in time. The store input stays closed from a fence request until its done pulse. No write is pending when done pulses. Written addresses are line-aligned. The cycle after each store shows the right fault or evict response. Merging, the mask-bit selection of bytes, allocation-order draining, the stall-and-flush when all entries are open, and the exact cycle of the done pulse depend on history over many stores. Only the bench's store sequences, checked against its own line model, can show those.

// File: rtl/wcsb_pkg.sv
package wcsb_pkg;

  // reason the head entry is being offered to the memory port
  typedef enum logic [1:0] {
    DR_NONE     = 2'd0,
    DR_FENCE    = 2'd1,
    DR_LINEFULL = 2'd2,
    DR_PRESSURE = 2'd3
  } drain_why_e;

endpackage

// File: rtl/wcsb_entry.sv
module wcsb_entry #(
  parameter int LINE_BYTES = 32,
  parameter int ST_BYTES   = 16,
  parameter int LN_W       = 27,
  parameter int HSEL_W     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic                    merge_i,
  input  logic                    clear_i,
  input  logic [LN_W-1:0]         line_i,
  input  logic [HSEL_W-1:0]       half_i,
  input  logic [8*ST_BYTES-1:0]   data_i,
  input  logic [ST_BYTES-1:0]     ben_i,
  output logic                    vld_o,
  output logic [LN_W-1:0]         line_o,
  output logic [8*LINE_BYTES-1:0] data_o,
  output logic [LINE_BYTES-1:0]   be_o
);

  logic                    vld_q, vld_n;
  logic [LN_W-1:0]         line_q;
  logic [LINE_BYTES-1:0]   be_q, be_n, wr_b;
  logic [8*LINE_BYTES-1:0] data_q, data_n;

  // per-byte write strobes: lane picked by the half select, byte by enable
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    localparam int LANE = b / ST_BYTES;
    localparam int K    = b % ST_BYTES;
    assign wr_b[b] = (alloc_i | merge_i) & (half_i == HSEL_W'(LANE)) & ben_i[K];
    always_comb begin
      data_n[8*b +: 8] = wr_b[b] ? data_i[8*K +: 8] : data_q[8*b +: 8];
    end
  end

  always_comb begin
    vld_n = vld_q;
    be_n  = be_q;
    if (clear_i) begin
      vld_n = 1'b0;
      be_n  = '0;
    end else if (alloc_i) begin
      vld_n = 1'b1;
      be_n  = wr_b;
    end else if (merge_i) begin
      be_n  = be_q | wr_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      be_q   <= '0;
      line_q <= '0;
    end else begin
      vld_q <= vld_n;
      be_q  <= be_n;
      if (alloc_i) line_q <= line_i;
    end
  end

  // data payload needs no reset: enables gate every use of it
  always_ff @(posedge clk) begin
    if (|wr_b) data_q <= data_n;
  end

  assign vld_o  = vld_q;
  assign line_o = line_q;
  assign data_o = data_q;
  assign be_o   = be_q;

endmodule

// File: rtl/wcsb_ctrl.sv
module wcsb_ctrl #(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic                       fence_req_i,
  output logic [$clog2(ENTRIES)-1:0] head_o,
  output logic [$clog2(ENTRIES)-1:0] tail_o,
  output logic                       full_o,
  output logic                       fence_busy_o,
  output logic                       fence_done_o
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [IDX_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n, done_q, done_n, fence_any;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (pop_i)  head_n = (head_q == IDX_W'(ENTRIES - 1)) ? '0 : head_q + 1'b1;
    if (push_i) tail_n = (tail_q == IDX_W'(ENTRIES - 1)) ? '0 : tail_q + 1'b1;
    cnt_n     = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    fence_any = busy_q | fence_req_i;
    busy_n    = fence_any & (cnt_n != '0);
    done_n    = fence_any & (cnt_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign head_o       = head_q;
  assign tail_o       = tail_q;
  assign full_o       = (cnt_q == CNT_W'(ENTRIES));
  assign fence_busy_o = busy_q;
  assign fence_done_o = done_q;

endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer
  import wcsb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ST_BYTES   = 16,
  parameter int ENTRIES    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [8*ST_BYTES-1:0]   st_data_i,
  input  logic                    st_masked_i,
  input  logic [8*ST_BYTES-1:0]   st_mask_i,
  input  logic                    st_cached_i,
  input  logic                    fence_req_i,
  output logic                    fence_done_o,
  output logic                    align_fault_o,
  output logic                    evict_valid_o,
  output logic [ADDR_W-1:0]       evict_addr_o,
  output logic                    mw_valid_o,
  input  logic                    mw_ready_i,
  output logic [ADDR_W-1:0]       mw_addr_o,
  output logic [8*LINE_BYTES-1:0] mw_data_o,
  output logic [LINE_BYTES-1:0]   mw_be_o
);

  localparam int OFS_W    = $clog2(LINE_BYTES);
  localparam int ST_OFS_W = $clog2(ST_BYTES);
  localparam int LN_W     = ADDR_W - OFS_W;
  localparam int HSEL_W   = OFS_W - ST_OFS_W;
  localparam int IDX_W    = $clog2(ENTRIES);

  logic [LN_W-1:0]         st_line;
  logic [HSEL_W-1:0]       st_half;
  logic                    misalign;
  logic [ST_BYTES-1:0]     st_ben;
  logic [7*ST_BYTES-1:0]   mask_low_unused;

  logic [ENTRIES-1:0]      e_vld, e_hit, e_alloc, e_merge, e_clear;
  logic [LN_W-1:0]         e_line [ENTRIES];
  logic [8*LINE_BYTES-1:0] e_data [ENTRIES];
  logic [LINE_BYTES-1:0]   e_be   [ENTRIES];

  logic [IDX_W-1:0]        head, tail, hit_idx;
  logic                    full, fence_busy, hit_any, press;
  logic                    st_fire, st_buf, drain_fire, head_busy_hit;
  drain_why_e              why;

  logic                    fault_q, fault_n, evict_q, evict_n;
  logic [ADDR_W-1:0]       evict_addr_q, evict_addr_n;

  assign st_line  = st_addr_i[ADDR_W-1:OFS_W];
  assign st_half  = st_addr_i[OFS_W-1:ST_OFS_W];
  assign misalign = |st_addr_i[ST_OFS_W-1:0];

  // only the top bit of each mask byte selects its byte
  for (genvar k = 0; k < ST_BYTES; k++) begin : g_ben
    assign st_ben[k]                 = ~st_masked_i | st_mask_i[8*k+7];
    assign mask_low_unused[7*k +: 7] = st_mask_i[8*k +: 7];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign e_hit[i]   = e_vld[i] & (e_line[i] == st_line);
    assign e_alloc[i] = st_buf & ~hit_any & (tail == IDX_W'(i));
    assign e_merge[i] = st_buf & e_hit[i];
    assign e_clear[i] = drain_fire & (head == IDX_W'(i));

    wcsb_entry #(
      .LINE_BYTES(LINE_BYTES),
      .ST_BYTES  (ST_BYTES),
      .LN_W      (LN_W),
      .HSEL_W    (HSEL_W)
    ) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc_i(e_alloc[i]),
      .merge_i(e_merge[i]),
      .clear_i(e_clear[i]),
      .line_i (st_line),
      .half_i (st_half),
      .data_i (st_data_i),
      .ben_i  (st_ben),
      .vld_o  (e_vld[i]),
      .line_o (e_line[i]),
      .data_o (e_data[i]),
      .be_o   (e_be[i])
    );
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (e_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  wcsb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (st_buf & ~hit_any),
    .pop_i       (drain_fire),
    .fence_req_i (fence_req_i),
    .head_o      (head),
    .tail_o      (tail),
    .full_o      (full),
    .fence_busy_o(fence_busy),
    .fence_done_o(fence_done_o)
  );

  // a store to a new line with every entry open forces the oldest out
  assign press = st_valid_i & ~misalign & ~hit_any & full & ~fence_busy & ~fence_req_i;

  always_comb begin
    why = DR_NONE;
    if (e_vld[head]) begin
      if (fence_busy)        why = DR_FENCE;
      else if (&e_be[head])  why = DR_LINEFULL;
      else if (press)        why = DR_PRESSURE;
    end
  end

  assign mw_valid_o    = (why != DR_NONE);
  assign drain_fire    = mw_valid_o & mw_ready_i;
  assign head_busy_hit = hit_any & (hit_idx == head) & mw_valid_o;

  assign st_ready_o = ~fence_busy & ~fence_req_i &
                      (misalign | (hit_any ? ~head_busy_hit : ~full));
  assign st_fire    = st_valid_i & st_ready_o;
  assign st_buf     = st_fire & ~misalign;

  assign mw_addr_o = {e_line[head], {OFS_W{1'b0}}};
  assign mw_data_o = e_data[head];
  assign mw_be_o   = e_be[head];

  always_comb begin
    fault_n      = st_fire & misalign;
    evict_n      = st_buf & st_cached_i;
    evict_addr_n = evict_addr_q;
    if (evict_n) evict_addr_n = {st_line, {OFS_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q      <= 1'b0;
      evict_q      <= 1'b0;
      evict_addr_q <= '0;
    end else begin
      fault_q      <= fault_n;
      evict_q      <= evict_n;
      evict_addr_q <= evict_addr_n;
    end
  end

  assign align_fault_o = fault_q;
  assign evict_valid_o = evict_q;
  assign evict_addr_o  = evict_addr_q;

endmodule

// File: rtl/wcsb_chk.sv
module wcsb_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ST_BYTES   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid_i,
  input logic              st_ready_o,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic              st_cached_i,
  input logic              fence_req_i,
  input logic              fence_done_o,
  input logic              align_fault_o,
  input logic              evict_valid_o,
  input logic [ADDR_W-1:0] evict_addr_o,
  input logic              mw_valid_o,
  input logic [ADDR_W-1:0] mw_addr_o
);

  localparam int OFS_W    = $clog2(LINE_BYTES);
  localparam int ST_OFS_W = $clog2(ST_BYTES);

  logic fence_open_q, fence_open_n;
  logic st_fire, st_mis;

  assign st_fire = st_valid_i & st_ready_o;
  assign st_mis  = |st_addr_i[ST_OFS_W-1:0];

  always_comb fence_open_n = (fence_open_q | fence_req_i) & ~fence_done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fence_open_q <= 1'b0;
    else        fence_open_q <= fence_open_n;
  end

  AST_FENCE_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req_i || (fence_open_q && !fence_done_o)) |-> !st_fire); // R6

  AST_DONE_NOTHING_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |-> !mw_valid_o); // R7

  AST_WRITE_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid_o |-> (mw_addr_o[OFS_W-1:0] == '0)); // R1

  AST_MISALIGN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && st_mis) |=> (align_fault_o && !evict_valid_o)); // R4

  AST_ALIGNED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && !st_mis) |=> !align_fault_o); // R4

  AST_EVICT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && !st_mis && st_cached_i) |=>
      (evict_valid_o && evict_addr_o == {$past(st_addr_i[ADDR_W-1:OFS_W]), {OFS_W{1'b0}}})); // R5

  AST_NO_EVICT_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && !st_cached_i) |=> !evict_valid_o); // R5

endmodule

bind wc_store_buffer wcsb_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .ST_BYTES  (ST_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid_i   (st_valid_i),
  .st_ready_o   (st_ready_o),
  .st_addr_i    (st_addr_i),
  .st_cached_i  (st_cached_i),
  .fence_req_i  (fence_req_i),
  .fence_done_o (fence_done_o),
  .align_fault_o(align_fault_o),
  .evict_valid_o(evict_valid_o),
  .evict_addr_o (evict_addr_o),
  .mw_valid_o   (mw_valid_o),
  .mw_addr_o    (mw_addr_o)
);

// File: tb/test_wc_store_buffer.sv
`timescale 1ns/1ps
module test_wc_store_buffer;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready, st_masked, st_cached;
  logic [31:0]  st_addr;
  logic [127:0] st_data, st_mask;
  logic         fence_req, fence_done, align_fault, evict_valid;
  logic [31:0]  evict_addr;
  logic         mw_valid, mw_ready;
  logic [31:0]  mw_addr;
  logic [255:0] mw_data;
  logic [31:0]  mw_be;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wc_store_buffer i_wc_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_masked_i(st_masked), .st_mask_i(st_mask),
    .st_cached_i(st_cached), .fence_req_i(fence_req), .fence_done_o(fence_done),
    .align_fault_o(align_fault), .evict_valid_o(evict_valid), .evict_addr_o(evict_addr),
    .mw_valid_o(mw_valid), .mw_ready_i(mw_ready), .mw_addr_o(mw_addr),
    .mw_data_o(mw_data), .mw_be_o(mw_be)
  );

  // write log filled by the monitor
  logic [31:0]  wr_addr [0:31];
  logic [255:0] wr_data [0:31];
  logic [31:0]  wr_be   [0:31];
  int n_wr = 0;
  int last_wr_cyc = 0;

  always begin
    @(negedge clk); #1;
    if (rst_n && mw_valid && mw_ready && n_wr < 32) begin
      wr_addr[n_wr] = mw_addr;
      wr_data[n_wr] = mw_data;
      wr_be[n_wr]   = mw_be;
      n_wr++;
      last_wr_cyc = cyc;
    end
  end

  // line model built from the requirements
  logic [26:0]  exp_line [0:7];
  logic [255:0] exp_dat  [0:7];
  logic [31:0]  exp_be   [0:7];
  int n_exp = 0;

  // addr, masked, per-byte select, cached
  localparam logic [49:0] VECS [0:5] = '{
    {32'h0000_0100, 1'b0, 16'h0000, 1'b1},
    {32'h0000_0210, 1'b1, 16'h00F0, 1'b0},
    {32'h0000_0110, 1'b1, 16'h8001, 1'b0},
    {32'h0000_0100, 1'b1, 16'h0F00, 1'b0},
    {32'h0000_0304, 1'b0, 16'h0000, 1'b1},
    {32'h0000_0400, 1'b0, 16'h0000, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mkdata(input int idx);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'(idx * 17 + k + 1);
    return d;
  endfunction

  // bit 7 carries the select; low bits set so they must be ignored
  function automatic logic [127:0] mkmask(input logic [15:0] sel);
    logic [127:0] m;
    for (int k = 0; k < 16; k++) m[8*k +: 8] = sel[k] ? 8'h80 : 8'h7F;
    return m;
  endfunction

  function automatic logic [255:0] be_expand(input logic [31:0] be);
    logic [255:0] x;
    for (int b = 0; b < 32; b++) x[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    return x;
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [127:0] d, input logic m, input logic [15:0] sel);
    int e;
    int h;
    e = -1;
    for (int j = 0; j < n_exp; j++) if (exp_line[j] == a[31:5]) e = j;
    if (e < 0) begin
      e = n_exp; n_exp++;
      exp_line[e] = a[31:5]; exp_be[e] = '0; exp_dat[e] = '0;
    end
    h = a[4] ? 16 : 0;
    for (int k = 0; k < 16; k++) begin
      if (!m || sel[k]) begin
        exp_be[e][h + k] = 1'b1;
        exp_dat[e][8*(h + k) +: 8] = d[8*k +: 8];
      end
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [127:0] d, input logic m,
                          input logic [127:0] mk, input logic c, output int stalls);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_masked = m; st_mask = mk; st_cached = c;
    stalls = 0;
    #1;
    while (!st_ready && stalls < 100) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
    #1;
  endtask

  task automatic do_fence(input logic probe, output int done_cyc, output logic blocked_ok, output logic seen);
    blocked_ok = 1'b1; seen = 1'b0; done_cyc = 0;
    @(negedge clk);
    fence_req = 1'b1;
    if (probe) begin
      st_valid = 1'b1; st_addr = 32'h0000_0F00; st_masked = 1'b0; st_cached = 1'b0;
    end
    #1;
    if (probe && st_ready) blocked_ok = 1'b0;
    @(negedge clk);
    fence_req = 1'b0;
    for (int w = 0; w < 200 && !seen; w++) begin
      #1;
      if (fence_done) begin
        seen = 1'b1; done_cyc = cyc; st_valid = 1'b0;
      end else begin
        if (probe && st_ready) blocked_ok = 1'b0;
        @(negedge clk);
      end
    end
    st_valid = 1'b0;
  endtask

  task automatic chk_wr(input int w, input logic [31:0] ea, input logic [31:0] ebe,
                        input logic [255:0] ed, input string tag);
    check(wr_addr[w] == ea, {tag, " address"}, 256'(wr_addr[w]), 256'(ea));
    check(wr_be[w] == ebe, {tag, " byte enables"}, 256'(wr_be[w]), 256'(ebe));
    check((wr_data[w] & be_expand(ebe)) == (ed & be_expand(ebe)), {tag, " data"},
          wr_data[w] & be_expand(ebe), ed & be_expand(ebe));
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int stalls, dcyc, base;
    logic blk, seen;
    logic [49:0] v;
    logic mis;

    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_masked = 1'b0;
    st_mask = '0; st_cached = 1'b0; fence_req = 1'b0; mw_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(st_ready == 1'b1, "R11 ready after reset", 256'(st_ready), 256'(1));
    check({mw_valid, fence_done, align_fault, evict_valid} == 4'b0, "R11 outputs idle after reset",
          256'({mw_valid, fence_done, align_fault, evict_valid}), 256'(0));

    // fence with nothing posted
    do_fence(1'b0, dcyc, blk, seen);
    check(seen, "R7 empty fence completes", 256'(seen), 256'(1));
    check(n_wr == 0, "R7 empty fence writes nothing", 256'(n_wr), 256'(0));

    // vector table walk
    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      mis = |v[21:18];
      do_store(v[49:18], mkdata(i), v[17], mkmask(v[16:1]), v[0], stalls);
      check(align_fault == mis, $sformatf("R4 fault flag for store %0d", i), 256'(align_fault), 256'(mis));
      check(evict_valid == (v[0] && !mis), $sformatf("R5 evict flag for store %0d", i),
            256'(evict_valid), 256'(v[0] && !mis));
      if (v[0] && !mis)
        check(evict_addr == {v[49:23], 5'b0}, $sformatf("R5 evict line for store %0d", i),
              256'(evict_addr), 256'({v[49:23], 5'b0}));
      if (!mis) model_store(v[49:18], mkdata(i), v[17], v[16:1]);
    end
    check(n_wr == 0, "R1 posted stores wait for drain", 256'(n_wr), 256'(0));
    check(n_exp == 3, "R2 merged stores share entries", 256'(n_exp), 256'(3));

    do_fence(1'b1, dcyc, blk, seen);
    check(blk, "R6 store held while fence drains", 256'(blk), 256'(1));
    check(seen, "R7 fence completes", 256'(seen), 256'(1));
    check(dcyc == last_wr_cyc + 1, "R7 done one cycle after last write", 256'(dcyc), 256'(last_wr_cyc + 1));
    check(n_wr == 3, "R8 all entries drained", 256'(n_wr), 256'(3));
    for (int j = 0; j < 3 && j < n_wr; j++)
      chk_wr(j, {exp_line[j], 5'b0}, exp_be[j], exp_dat[j], $sformatf("R1 R2 R3 R8 write %0d", j));

    // full line drains on its own
    base = n_wr;
    do_store(32'h0000_0500, mkdata(7), 1'b0, '0, 1'b0, stalls);
    do_store(32'h0000_0510, mkdata(8), 1'b0, '0, 1'b0, stalls);
    repeat (3) @(negedge clk);
    check(n_wr == base + 1, "R10 full line written without fence", 256'(n_wr), 256'(base + 1));
    if (n_wr > base)
      chk_wr(base, 32'h0000_0500, 32'hFFFF_FFFF, {mkdata(8), mkdata(7)}, "R10 full line");

    // all entries open, new line forces the oldest out
    base = n_wr;
    do_store(32'h0000_0600, mkdata(9),  1'b0, '0, 1'b0, stalls);
    do_store(32'h0000_0700, mkdata(10), 1'b0, '0, 1'b0, stalls);
    do_store(32'h0000_0800, mkdata(11), 1'b0, '0, 1'b0, stalls);
    do_store(32'h0000_0900, mkdata(12), 1'b0, '0, 1'b0, stalls);
    check(n_wr == base, "R9 four partial lines stay posted", 256'(n_wr), 256'(base));
    do_store(32'h0000_0A00, mkdata(13), 1'b0, '0, 1'b0, stalls);
    check(stalls == 1, "R9 fifth line held one cycle", 256'(stalls), 256'(1));
    check(n_wr == base + 1, "R9 oldest entry flushed", 256'(n_wr), 256'(base + 1));
    if (n_wr > base)
      chk_wr(base, 32'h0000_0600, 32'h0000_FFFF, {128'h0, mkdata(9)}, "R9 oldest line");
    do_fence(1'b0, dcyc, blk, seen);
    check(n_wr == base + 5, "R8 remaining entries drained", 256'(n_wr), 256'(base + 5));
    for (int j = 1; j < 5 && base + j < n_wr; j++)
      check(wr_addr[base + j] == 32'h0000_0600 + 32'(j) * 32'h100, $sformatf("R8 drain order %0d", j),
            256'(wr_addr[base + j]), 256'(32'h0000_0600 + 32'(j) * 32'h100));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule